// File: doc/BRIEF.md
# Vector Result Output Conditioner

This stage sits between a SIMD arithmetic unit and register writeback. It takes one 128-bit result vector per transfer, together with a lane-width code, a float/integer flag, a two-bit modifier code and a two-bit narrowing selector. It returns the value to be written and a byte write-enable mask for the destination register.

Float results in 16-bit or 32-bit IEEE lanes can be limited to one of three ranges, and each range has its own fixed replacement for NaN. Integer results whose lanes are twice the destination lane width can be narrowed by signed saturation, unsigned saturation, or by keeping the low or the high half of each lane. The packed narrowed result goes into the lower or upper 64 bits of the destination, and only those bytes are enabled.

Both sides use valid/ready handshakes. A transfer is accepted when `in_valid` and `in_ready` are high at a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The output holds its value while `out_valid` is high and `out_ready` is low.

Top module: `vomod_top`

## Requirements
- R1: Float pass-through. With `is_float`=1, modifier code 0 leaves every lane unchanged. A float modifier with lane code 0 (8-bit) or 3 (64-bit) also leaves the value unchanged. All 16 byte enables are high for every float transfer, whatever the narrowing selector holds.
- R2: Float code 1 (non-negative floor): a negative lane, including -0.0, becomes +0.0. A NaN lane becomes +0.0. Any other lane is unchanged.
- R3: Float code 2 (signed unit range): a lane with magnitude above 1.0 becomes +1.0 or -1.0 with its own sign. A NaN lane becomes -1.0 (0xBC00 in 16-bit lanes, 0xBF800000 in 32-bit lanes). Other lanes are unchanged.
- R4: Float code 3 (unit range): negative lanes and NaN lanes become +0.0. Lanes above 1.0 become +1.0 (0x3C00 or 0x3F800000). Other lanes are unchanged.
- R5: The lane code sets the destination lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Float clamping applies to 16-bit lanes under code 1 and to 32-bit lanes under code 2.
- R6: Integer code 0 with narrowing: each 2N-bit source lane k becomes N-bit result k, saturated to the signed range [-2^(N-1), 2^(N-1)-1].
- R7: Integer code 1 with narrowing: each source lane, read as unsigned, is saturated to [0, 2^N-1].
- R8: Integer code 2 keeps the low N bits of each source lane, and code 3 keeps the high N bits.
- R9: Narrowing selector 0 places the 64-bit narrowed result in bits 63:0 with byte enables 0x00FF. Selector 1 places it in bits 127:64 with byte enables 0xFF00. The disabled half reads as zero.
- R10: Narrowing selector 2 (and the spare code 3) means no narrowing. The integer input passes unchanged with all byte enables high, and the integer modifier code has no effect.
- R11: An accepted transfer appears on the output at the next rising edge. While `out_valid` is high and `out_ready` is low, the output data and enables hold and no new transfer is accepted.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Stage can accept a transfer |
| in_data | input | 128 | Raw ALU result vector |
| lane_mode | input | 2 | Destination lane width code |
| is_float | input | 1 | 1 = float modifiers, 0 = integer modifiers |
| omod | input | 2 | Output modifier code |
| shrink | input | 2 | Narrowing selector |
| out_valid | output | 1 | Output transfer valid |
| out_ready | input | 1 | Consumer accepts output |
| out_data | output | 128 | Value to write back |
| out_be | output | 16 | Byte write enables, bit i covers bits 8i+7:8i |

## Verification
Every conditioned result and its byte-enable mask are due at the first rising edge after the transfer is accepted. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each sample falls exactly one register stage after acceptance. During back-pressure the bench samples over several falling edges to confirm the held value. It then reads the transfer that was waiting, one edge after the stall is released.

// File: rtl/vomod_pkg.sv
package vomod_pkg;
  localparam logic [1:0] LANE_8  = 2'd0;
  localparam logic [1:0] LANE_16 = 2'd1;
  localparam logic [1:0] LANE_32 = 2'd2;
  localparam logic [1:0] LANE_64 = 2'd3;

  localparam logic [1:0] FM_PASS  = 2'd0;
  localparam logic [1:0] FM_FLOOR = 2'd1;
  localparam logic [1:0] FM_SUNIT = 2'd2;
  localparam logic [1:0] FM_UNIT  = 2'd3;

  localparam logic [1:0] IM_SSAT = 2'd0;
  localparam logic [1:0] IM_USAT = 2'd1;
  localparam logic [1:0] IM_LOW  = 2'd2;
  localparam logic [1:0] IM_HIGH = 2'd3;

  localparam logic [1:0] SH_LOWER = 2'd0;
  localparam logic [1:0] SH_UPPER = 2'd1;
endpackage

// File: rtl/vomod_fclamp.sv
module vomod_fclamp
  import vomod_pkg::*;
#(
  parameter int EW     = 16,
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] vec_i,
  input  logic [1:0]        code_i,
  output logic [DATA_W-1:0] vec_o
);
  localparam int MANT_W = (EW == 16) ? 10 : 23;
  localparam int EXP_W  = EW - 1 - MANT_W;
  localparam int LANES  = DATA_W / EW;
  localparam logic [EW-1:0] ONE_BITS = {2'b00, {(EXP_W-1){1'b1}}, {MANT_W{1'b0}}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EW-1:0] x, y;
    logic          sgn, nan, above;
    assign x     = vec_i[l*EW +: EW];
    assign sgn   = x[EW-1];
    assign nan   = (&x[EW-2:MANT_W]) && (|x[MANT_W-1:0]);
    assign above = x[EW-2:0] > ONE_BITS[EW-2:0];

    always_comb begin
      case (code_i)
        FM_FLOOR: y = (nan || sgn) ? '0 : x;
        FM_SUNIT: begin
          if (nan)        y = {1'b1, ONE_BITS[EW-2:0]};
          else if (above) y = {sgn, ONE_BITS[EW-2:0]};
          else            y = x;
        end
        FM_UNIT: begin
          if (nan || sgn) y = '0;
          else if (above) y = ONE_BITS;
          else            y = x;
        end
        default: y = x;
      endcase
    end

    assign vec_o[l*EW +: EW] = y;

    // R4: unit range output never negative and never above one
    always_comb begin
      if (code_i == FM_UNIT) begin
        a_r4_unit_range: assert (!y[EW-1] && (y[EW-2:0] <= ONE_BITS[EW-2:0]));
      end
      // R3: signed unit range output magnitude never above one
      if (code_i == FM_SUNIT) begin
        a_r3_sunit_range: assert (y[EW-2:0] <= ONE_BITS[EW-2:0]);
      end
    end
  end
endmodule

// File: rtl/vomod_inarrow.sv
module vomod_inarrow
  import vomod_pkg::*;
#(
  parameter int NW     = 8,
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0]   vec_i,
  input  logic [1:0]          code_i,
  output logic [DATA_W/2-1:0] half_o
);
  localparam int SW    = 2 * NW;
  localparam int LANES = DATA_W / SW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NW-1:0] hi, lo, y;
    logic          s_fit, u_fit;
    assign hi    = vec_i[l*SW+NW +: NW];
    assign lo    = vec_i[l*SW +: NW];
    assign s_fit = (hi == {NW{lo[NW-1]}});
    assign u_fit = (hi == '0);

    always_comb begin
      case (code_i)
        IM_SSAT: y = s_fit ? lo : (hi[NW-1] ? {1'b1, {(NW-1){1'b0}}} : {1'b0, {(NW-1){1'b1}}});
        IM_USAT: y = u_fit ? lo : '1;
        IM_HIGH: y = hi;
        default: y = lo;
      endcase
    end

    assign half_o[l*NW +: NW] = y;

    // R7: unsigned saturation yields all ones unless the upper half was clear
    always_comb begin
      if (code_i == IM_USAT) begin
        a_r7_usat_ceiling: assert ((y == '1) || (hi == '0));
      end
    end
  end
endmodule

// File: rtl/vomod_top.sv
module vomod_top
  import vomod_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [1:0]          lane_mode,
  input  logic                is_float,
  input  logic [1:0]          omod,
  input  logic [1:0]          shrink,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic [DATA_W/8-1:0] out_be
);
  localparam int HALF   = DATA_W / 2;
  localparam int BE_W   = DATA_W / 8;
  localparam int BE_H   = BE_W / 2;
  localparam int NWIDTH = 4;

  logic [DATA_W-1:0] f16_vec, f32_vec;
  logic [HALF-1:0]   nar [NWIDTH];
  logic [DATA_W-1:0] nxt_data;
  logic [BE_W-1:0]   nxt_be;

  vomod_fclamp #(.EW(16), .DATA_W(DATA_W)) u_f16 (
    .vec_i(in_data), .code_i(omod), .vec_o(f16_vec)
  );
  vomod_fclamp #(.EW(32), .DATA_W(DATA_W)) u_f32 (
    .vec_i(in_data), .code_i(omod), .vec_o(f32_vec)
  );

  for (genvar g = 0; g < NWIDTH; g++) begin : g_nar
    vomod_inarrow #(.NW(8 << g), .DATA_W(DATA_W)) u_nar (
      .vec_i(in_data), .code_i(omod), .half_o(nar[g])
    );
  end

  always_comb begin
    nxt_data = in_data;
    nxt_be   = '1;
    if (is_float) begin
      if (lane_mode == LANE_16)      nxt_data = f16_vec;
      else if (lane_mode == LANE_32) nxt_data = f32_vec;
    end else if (shrink == SH_LOWER) begin
      nxt_data = {{HALF{1'b0}}, nar[lane_mode]};
      nxt_be   = {{BE_H{1'b0}}, {BE_H{1'b1}}};
    end else if (shrink == SH_UPPER) begin
      nxt_data = {nar[lane_mode], {HALF{1'b0}}};
      nxt_be   = {{BE_H{1'b1}}, {BE_H{1'b0}}};
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_be   <= nxt_be;
      end
    end
  end

  // R11: an accepted transfer is presented at the next edge
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R11: stalled output holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be));

  // R9: a disabled half reads as zero
  a_r9_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_be == {{BE_H{1'b0}}, {BE_H{1'b1}}}) |-> (out_data[DATA_W-1:HALF] == '0));
  a_r9_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_be == {{BE_H{1'b1}}, {BE_H{1'b0}}}) |-> (out_data[HALF-1:0] == '0));
endmodule

// File: tb/tb_vomod_top.sv
module tb_vomod_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data;
  logic [1:0]   lane_mode;
  logic         is_float;
  logic [1:0]   omod;
  logic [1:0]   shrink;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;
  logic [15:0]  out_be;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vomod_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lane_mode(lane_mode), .is_float(is_float), .omod(omod),
    .shrink(shrink), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_be(out_be)
  );

  typedef struct packed {
    logic [7:0]   req;
    logic [1:0]   lane;
    logic         flt;
    logic [1:0]   om;
    logic [1:0]   sh;
    logic [127:0] din;
    logic [127:0] dexp;
    logic [15:0]  be;
  } vec_t;

  localparam logic [127:0] F32_IN = {32'hC0000000, 32'h7FC00000, 32'h40000000, 32'h3F000000};
  localparam logic [127:0] F16_IN = {2{16'hC000, 16'h7E00, 16'h4000, 16'h3800}};
  localparam logic [127:0] I16_IN = {64'h0, 16'h0100, 16'hFF00, 16'h007F, 16'hFF80,
                                     16'h0005, 16'hFFFF, 16'h0080, 16'hFF7F} >> 0;
  localparam logic [127:0] I16_SRC = {16'h0100, 16'hFF00, 16'h007F, 16'hFF80,
                                      16'h0005, 16'hFFFF, 16'h0080, 16'hFF7F};
  localparam logic [127:0] I32_SRC = {32'h12345678, 32'h9ABCDEF0, 32'h0F0F1234, 32'hAAAA5555};

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R1 float code 0 passes 32-bit lanes
    '{8'd1, 2'd2, 1'b1, 2'd0, 2'd2, F32_IN, F32_IN, 16'hFFFF},
    // R2 floor at zero
    '{8'd2, 2'd2, 1'b1, 2'd1, 2'd2, F32_IN,
      {32'h0, 32'h0, 32'h40000000, 32'h3F000000}, 16'hFFFF},
    // R3 signed unit range, NaN to -1
    '{8'd3, 2'd2, 1'b1, 2'd2, 2'd2, F32_IN,
      {32'hBF800000, 32'hBF800000, 32'h3F800000, 32'h3F000000}, 16'hFFFF},
    // R4 unit range
    '{8'd4, 2'd2, 1'b1, 2'd3, 2'd2, F32_IN,
      {32'h0, 32'h0, 32'h3F800000, 32'h3F000000}, 16'hFFFF},
    // R5 unit range in 16-bit lanes
    '{8'd5, 2'd1, 1'b1, 2'd3, 2'd2, F16_IN,
      {2{16'h0000, 16'h0000, 16'h3C00, 16'h3800}}, 16'hFFFF},
    // R5 signed unit range in 16-bit lanes
    '{8'd5, 2'd1, 1'b1, 2'd2, 2'd2, F16_IN,
      {2{16'hBC00, 16'hBC00, 16'h3C00, 16'h3800}}, 16'hFFFF},
    // R1 float modifier on 8-bit lanes passes
    '{8'd1, 2'd0, 1'b1, 2'd3, 2'd2, F16_IN, F16_IN, 16'hFFFF},
    // R1 float modifier on 64-bit lanes passes, shrink selector ignored
    '{8'd1, 2'd3, 1'b1, 2'd1, 2'd0, F32_IN, F32_IN, 16'hFFFF},
    // R6 signed saturation to 8 bits, lower half
    '{8'd6, 2'd0, 1'b0, 2'd0, 2'd0, I16_SRC,
      {64'h0, 64'h7F807F8005FF7F80}, 16'h00FF},
    // R7 unsigned saturation to 8 bits, upper half
    '{8'd7, 2'd0, 1'b0, 2'd1, 2'd1, I16_SRC,
      {64'hFFFF7FFF05FF80FF, 64'h0}, 16'hFF00},
    // R8 keep high to 16 bits, lower half
    '{8'd8, 2'd1, 1'b0, 2'd3, 2'd0, I32_SRC,
      {64'h0, 64'h12349ABC0F0FAAAA}, 16'h00FF},
    // R8 keep low to 32 bits, upper half
    '{8'd8, 2'd2, 1'b0, 2'd2, 2'd1, I32_SRC,
      {64'h9ABCDEF0AAAA5555, 64'h0}, 16'hFF00},
    // R6 signed saturation to 64 bits
    '{8'd6, 2'd3, 1'b0, 2'd0, 2'd0, {64'h1, 64'h0},
      {64'h0, 64'h7FFFFFFFFFFFFFFF}, 16'h00FF},
    // R10 no narrowing, saturation code ignored
    '{8'd10, 2'd0, 1'b0, 2'd0, 2'd2, I16_SRC, I16_SRC, 16'hFFFF},
    // R10 spare selector 3 also passes
    '{8'd10, 2'd1, 1'b0, 2'd3, 2'd3, I32_SRC, I32_SRC, 16'hFFFF}
  };

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] ln, input logic fl, input logic [1:0] om,
                      input logic [1:0] sh, input logic [127:0] d);
    @(negedge clk);
    lane_mode = ln; is_float = fl; omod = om; shrink = sh; in_data = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
    lane_mode = '0; is_float = 1'b0; omod = '0; shrink = 2'd2;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 out_valid", {127'b0, out_valid}, 128'd0);
    check("R12 in_ready", {127'b0, in_ready}, 128'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].lane, VEC[i].flt, VEC[i].om, VEC[i].sh, VEC[i].din);
      check($sformatf("R%0d vec%0d valid", VEC[i].req, i), {127'b0, out_valid}, 128'd1);
      check($sformatf("R%0d vec%0d data", VEC[i].req, i), out_data, VEC[i].dexp);
      check($sformatf("R%0d vec%0d be", VEC[i].req, i), {112'b0, out_be}, {112'b0, VEC[i].be});
    end

    // R11 back-pressure: first item held, second waits
    @(negedge clk);
    out_ready = 1'b0;
    lane_mode = 2'd2; is_float = 1'b1; omod = 2'd0; shrink = 2'd2; in_data = F32_IN;
    in_valid = 1'b1;
    @(negedge clk);
    check("R11 stall data", out_data, F32_IN);
    check("R11 stall ready", {127'b0, in_ready}, 128'd0);
    in_data = I32_SRC; is_float = 1'b0;
    @(negedge clk);
    check("R11 held data", out_data, F32_IN);
    check("R11 held valid", {127'b0, out_valid}, 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 released data", out_data, I32_SRC);
    @(negedge clk);
    check("R11 drained", {127'b0, out_valid}, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule